// File: doc/BRIEF.md
# Clocked Serial Shift Port

This block moves one byte over a two-wire synchronous link: a shift clock that it generates itself, and a single data line that it either drives (transmit) or samples (receive). The block runs on the fast system clock, one cycle of which is the unit of all timing below. A host loads a 16-bit rate word, a direction and, for transmit, a byte, then pulses `start`. The block runs eight clock pulses, least significant bit first, and ends with a one-cycle `done` strobe.

The rate word has two parts. Its top bit enables the internal clock source; without it, no frame starts. Its lower bits set the length of the low phase of the shift clock. Transmit and receive have different minimum settings, because receive needs a longer low phase to let the far end's data settle before the sample. Data moves at fixed offsets from the rising clock edge. The receiver samples on the rising edge. The transmitter keeps each bit for two cycles after that edge, then presents the next bit.

Top module: `ssp_sync_port`

## Requirements
- R1: After reset the shift clock `sclk` is high, `sd_oe` is low, `busy` and `done` are low and `rx_byte` is zero.
- R2: A `start` pulse begins a frame only when `busy` is low and `baud_cfg[15]` is 1. Otherwise it is ignored. This includes a pulse in the cycle in which a frame completes.
- R3: Let D be `baud_cfg[14:0]`, raised to 1 for transmit and to 2 for receive when it is smaller. Each frame then has 8 clock periods, each with `sclk` low for 2*D cycles followed by high for 2 cycles. The first low phase starts in the cycle after `start` is accepted, and `sclk` rests high outside a frame.
- R4: Transmit (`dir_rx`=0) sends `tx_byte` LSB first. Bit 0 is on `sd_out` from the cycle after acceptance. Each next bit appears exactly 2 cycles after a rising edge of `sclk`, so it is constant through every high phase.
- R5: `sd_oe` is high during a transmit frame from acceptance until 2 cycles after the 8th rising edge, then low. It stays low for a whole receive frame (`dir_rx`=1).
- R6: In receive, `sd_in` is captured at each rising edge of `sclk`, the first capture being bit 0. The assembled byte appears on `rx_byte` in the `done` cycle and is held until the next receive frame completes.
- R7: `busy` is high from the cycle after acceptance to the end of the frame. `done` is a single-cycle pulse 2 cycles after the 8th rising edge, in the same cycle in which `busy` falls.
- R8: Changes of `baud_cfg`, `dir_rx` or `tx_byte` while `busy` is high do not alter the running frame's clock, direction or data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, one cycle per timing unit |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a frame |
| dir_rx | input | 1 | 0 = transmit, 1 = receive |
| baud_cfg | input | 16 | Bit 15 enables the clock source, bits 14:0 set the divider |
| tx_byte | input | 8 | Byte to send |
| sd_in | input | 1 | Data line as seen at the pad |
| sclk | output | 1 | Shift clock, idles high |
| sd_out | output | 1 | Data value to drive |
| sd_oe | output | 1 | Drive enable for the data line |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame strobe |
| rx_byte | output | 8 | Last received byte |

## Verification
A new `start` can arrive in the same cycle in which a frame completes. The acceptance and the completion then share one clock edge. The bench raises `start` in the last high-phase cycle of a frame. It expects `done` in the next cycle and no second frame: `busy` stays low and `sclk` stays high for several cycles. It also raises `start` in mid-frame, together with a new rate, direction and byte, and compares the full `sclk`/`sd_out`/`sd_oe` waveform against the one computed from the original settings.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  // Length of the high phase of the shift clock, in system cycles.
  localparam int unsigned HIGH_CYC = 2;

  typedef enum logic {
    XFER_TX = 1'b0,
    XFER_RX = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/ssp_rate.sv
// Decodes the rate word: clock source enable and the clamped low-phase length.
module ssp_rate #(
  parameter int unsigned BAUD_W = 16,
  parameter int unsigned TX_MIN = 1,
  parameter int unsigned RX_MIN = 2
) (
  input  logic [BAUD_W-1:0] baud_cfg,
  input  logic              dir_rx,
  output logic              src_ok,
  output logic [BAUD_W-1:0] low_len
);
  localparam int unsigned DIV_W = BAUD_W - 1;

  logic [DIV_W-1:0] div_raw;
  logic [DIV_W-1:0] div_min;
  logic [DIV_W-1:0] div_eff;

  always_comb begin
    div_raw = baud_cfg[DIV_W-1:0];
    div_min = dir_rx ? DIV_W'(RX_MIN) : DIV_W'(TX_MIN);
    div_eff = (div_raw < div_min) ? div_min : div_raw;
    src_ok  = baud_cfg[BAUD_W-1];
    low_len = {div_eff, 1'b0};
  end
endmodule

// File: rtl/ssp_timer.sv
// Shift clock generator: low phase of low_len cycles, high phase of HIGH_CYC.
module ssp_timer
  import ssp_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned FRAME_BITS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic [CNT_W-1:0] low_len,
  output logic             active,
  output logic             sclk,
  output logic             rise_now,
  output logic             fall_now,
  output logic             end_now
);
  localparam int unsigned BIT_W = $clog2(FRAME_BITS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_q;
  logic [BIT_W-1:0] bits_q;
  logic             phase_end;
  logic             last_bit;

  always_comb begin
    phase_end = active && (cnt_q == '0);
    last_bit  = (bits_q == BIT_W'(FRAME_BITS));
    rise_now  = phase_end && !sclk;
    fall_now  = phase_end && sclk && !last_bit;
    end_now   = phase_end && sclk && last_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      sclk   <= 1'b1;
      cnt_q  <= '0;
      len_q  <= '0;
      bits_q <= '0;
    end else if (launch) begin
      active <= 1'b1;
      sclk   <= 1'b0;
      cnt_q  <= low_len - CNT_W'(1);
      len_q  <= low_len;
      bits_q <= '0;
    end else if (rise_now) begin
      sclk   <= 1'b1;
      cnt_q  <= CNT_W'(HIGH_CYC - 1);
      bits_q <= bits_q + BIT_W'(1);
    end else if (fall_now) begin
      sclk   <= 1'b0;
      cnt_q  <= len_q - CNT_W'(1);
    end else if (end_now) begin
      active <= 1'b0;
    end else if (active) begin
      cnt_q  <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/ssp_shift.sv
// Data path: transmit shifter with output enable, receive capture register.
module ssp_shift
  import ssp_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  launch,
  input  logic                  dir_rx,
  input  logic [FRAME_BITS-1:0] tx_byte,
  input  logic                  sd_in,
  input  logic                  rise_now,
  input  logic                  fall_now,
  input  logic                  end_now,
  output logic                  sd_out,
  output logic                  sd_oe,
  output logic                  done,
  output logic [FRAME_BITS-1:0] rx_byte
);
  logic [FRAME_BITS-1:0] sh_q;
  xfer_dir_e             dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q    <= '0;
      dir_q   <= XFER_TX;
      sd_out  <= 1'b0;
      sd_oe   <= 1'b0;
      done    <= 1'b0;
      rx_byte <= '0;
    end else begin
      done <= 1'b0;
      if (launch) begin
        dir_q  <= dir_rx ? XFER_RX : XFER_TX;
        sh_q   <= tx_byte;
        sd_out <= tx_byte[0];
        sd_oe  <= !dir_rx;
      end else if (rise_now && dir_q == XFER_RX) begin
        sh_q <= {sd_in, sh_q[FRAME_BITS-1:1]};
      end else if (fall_now && dir_q == XFER_TX) begin
        sh_q   <= {1'b0, sh_q[FRAME_BITS-1:1]};
        sd_out <= sh_q[1];
      end else if (end_now) begin
        sd_oe <= 1'b0;
        done  <= 1'b1;
        if (dir_q == XFER_RX) begin
          rx_byte <= sh_q;
        end
      end
    end
  end
endmodule

// File: rtl/ssp_sync_port.sv
module ssp_sync_port #(
  parameter int unsigned FRAME_BITS = 8,
  parameter int unsigned BAUD_W     = 16,
  parameter int unsigned TX_MIN_DIV = 1,
  parameter int unsigned RX_MIN_DIV = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  dir_rx,
  input  logic [BAUD_W-1:0]     baud_cfg,
  input  logic [FRAME_BITS-1:0] tx_byte,
  input  logic                  sd_in,
  output logic                  sclk,
  output logic                  sd_out,
  output logic                  sd_oe,
  output logic                  busy,
  output logic                  done,
  output logic [FRAME_BITS-1:0] rx_byte
);
  logic              src_ok;
  logic [BAUD_W-1:0] low_len;
  logic              launch;
  logic              rise_now;
  logic              fall_now;
  logic              end_now;

  assign launch = start && !busy && src_ok;

  ssp_rate #(
    .BAUD_W (BAUD_W),
    .TX_MIN (TX_MIN_DIV),
    .RX_MIN (RX_MIN_DIV)
  ) i_rate (
    .baud_cfg (baud_cfg),
    .dir_rx   (dir_rx),
    .src_ok   (src_ok),
    .low_len  (low_len)
  );

  ssp_timer #(
    .CNT_W      (BAUD_W),
    .FRAME_BITS (FRAME_BITS)
  ) i_timer (
    .clk      (clk),
    .rst      (rst),
    .launch   (launch),
    .low_len  (low_len),
    .active   (busy),
    .sclk     (sclk),
    .rise_now (rise_now),
    .fall_now (fall_now),
    .end_now  (end_now)
  );

  ssp_shift #(
    .FRAME_BITS (FRAME_BITS)
  ) i_shift (
    .clk      (clk),
    .rst      (rst),
    .launch   (launch),
    .dir_rx   (dir_rx),
    .tx_byte  (tx_byte),
    .sd_in    (sd_in),
    .rise_now (rise_now),
    .fall_now (fall_now),
    .end_now  (end_now),
    .sd_out   (sd_out),
    .sd_oe    (sd_oe),
    .done     (done),
    .rx_byte  (rx_byte)
  );
endmodule

// File: rtl/ssp_sync_port_chk.sv
module ssp_sync_port_chk #(
  parameter int unsigned FRAME_BITS = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  sclk,
  input logic                  sd_out,
  input logic                  sd_oe,
  input logic                  busy,
  input logic                  done,
  input logic [FRAME_BITS-1:0] rx_byte
);
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $fell(busy));

  // R5
  oe_inside_frame_chk: assert property (@(posedge clk) disable iff (rst)
    sd_oe |-> busy);

  // R3
  idle_clock_high_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> sclk);

  // R3
  high_two_cycles_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(sclk) && busy) |=> sclk);

  // R4
  tx_hold_high_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(sclk) && sd_oe) |=> $stable(sd_out));

  // R6
  rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(rx_byte));
endmodule

bind ssp_sync_port ssp_sync_port_chk #(
  .FRAME_BITS (FRAME_BITS)
) i_chk (
  .clk     (clk),
  .rst     (rst),
  .sclk    (sclk),
  .sd_out  (sd_out),
  .sd_oe   (sd_oe),
  .busy    (busy),
  .done    (done),
  .rx_byte (rx_byte)
);

// File: tb/test_ssp_sync_port.sv
module test_ssp_sync_port;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       dir_rx = 1'b0;
  logic [15:0] baud_cfg = 16'h8001;
  logic [7:0] tx_byte = 8'h00;
  logic       sd_in = 1'b0;
  logic       sclk, sd_out, sd_oe, busy, done;
  logic [7:0] rx_byte;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ssp_sync_port i_ssp_sync_port (
    .clk(clk), .rst(rst), .start(start), .dir_rx(dir_rx),
    .baud_cfg(baud_cfg), .tx_byte(tx_byte), .sd_in(sd_in),
    .sclk(sclk), .sd_out(sd_out), .sd_oe(sd_oe), .busy(busy),
    .done(done), .rx_byte(rx_byte)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // R1: reset values
  task automatic test_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "sclk", {31'b0, sclk}, 1);
    chk("R1", "sd_oe", {31'b0, sd_oe}, 0);
    chk("R1", "busy", {31'b0, busy}, 0);
    chk("R1", "done", {31'b0, done}, 0);
    chk("R1", "rx_byte", {24'b0, rx_byte}, 0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // One frame, compared cycle by cycle with the waveform built from R3..R8.
  task automatic run_frame(input bit rx, input logic [15:0] cfg,
                           input logic [7:0] data, input bit disturb,
                           input bit late_start);
    int d;
    int per;
    int min_d;
    min_d = rx ? 2 : 1;
    d = int'(cfg[14:0]);
    if (d < min_d) d = min_d;
    per = 2 * d + 2;
    dir_rx = rx;
    baud_cfg = cfg;
    tx_byte = rx ? 8'h00 : data;
    sd_in = data[0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < 8 * per; t++) begin
      int k;
      int p;
      k = t / per;
      p = t % per;
      if (rx) sd_in = data[k];
      chk("R3", "sclk", {31'b0, sclk}, (p >= 2 * d) ? 1 : 0);
      chk("R7", "busy", {31'b0, busy}, 1);
      chk("R7", "done", {31'b0, done}, 0);
      chk("R5", "sd_oe", {31'b0, sd_oe}, rx ? 0 : 1);
      if (!rx) chk("R4", "sd_out", {31'b0, sd_out}, {31'b0, data[k]});
      if (disturb && t == 5) begin
        // R8: mid-frame start and new settings must not matter
        start = 1'b1;
        baud_cfg = 16'h8007;
        tx_byte = ~data;
        dir_rx = !rx;
      end
      if (disturb && t == 6) start = 1'b0;
      // R2: start in the cycle that completes the frame
      if (late_start && t == 8 * per - 1) start = 1'b1;
      @(negedge clk);
    end
    start = 1'b0;
    chk("R7", "done at end", {31'b0, done}, 1);
    chk("R7", "busy at end", {31'b0, busy}, 0);
    chk("R5", "sd_oe at end", {31'b0, sd_oe}, 0);
    chk("R3", "sclk at end", {31'b0, sclk}, 1);
    if (rx) chk("R6", "rx_byte", {24'b0, rx_byte}, {24'b0, data});
    @(negedge clk);
    chk("R7", "done pulse width", {31'b0, done}, 0);
    if (rx) chk("R6", "rx_byte held", {24'b0, rx_byte}, {24'b0, data});
    if (late_start) begin
      for (int i = 0; i < 4; i++) begin
        chk("R2", "no frame from late start", {31'b0, busy}, 0);
        chk("R2", "clock idle after late start", {31'b0, sclk}, 1);
        @(negedge clk);
      end
    end
    dir_rx = rx;
  endtask

  // R2: clock source disabled, start ignored
  task automatic test_no_source;
    baud_cfg = 16'h0003;
    dir_rx = 1'b0;
    tx_byte = 8'hFF;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 10; i++) begin
      chk("R2", "busy with source off", {31'b0, busy}, 0);
      chk("R2", "sclk with source off", {31'b0, sclk}, 1);
      chk("R2", "sd_oe with source off", {31'b0, sd_oe}, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
      $finish;
    end
  end

  initial begin
    test_reset();
    run_frame(1'b0, 16'h8001, 8'hA5, 1'b0, 1'b0);
    run_frame(1'b0, 16'h8003, 8'h3C, 1'b0, 1'b0);
    run_frame(1'b0, 16'h8000, 8'h81, 1'b0, 1'b0);
    run_frame(1'b1, 16'h8000, 8'h5A, 1'b0, 1'b0);
    run_frame(1'b1, 16'h8001, 8'h96, 1'b0, 1'b0);
    run_frame(1'b1, 16'h8005, 8'hC3, 1'b0, 1'b0);
    run_frame(1'b0, 16'h8002, 8'h6E, 1'b1, 1'b0);
    run_frame(1'b1, 16'h8002, 8'h17, 1'b1, 1'b0);
    run_frame(1'b0, 16'h8001, 8'hE2, 1'b0, 1'b1);
    run_frame(1'b1, 16'h8004, 8'h4B, 1'b0, 1'b1);
    // R6: a transmit frame leaves the received byte alone
    run_frame(1'b0, 16'h8001, 8'h00, 1'b0, 1'b0);
    chk("R6", "rx_byte kept over tx frame", {24'b0, rx_byte}, 32'h4B);
    test_no_source();
    finished = 1'b1;
    report();
    $finish;
  end
endmodule